// File: doc/BRIEF.md
# Register-Write Command Packer

This block turns a stream of register-write requests into a packed command buffer held in a word-addressed local memory. Each request carries a register offset, a 32-bit data word and a mode bit. In direct mode the request becomes one two-word command: the data word, then a header word holding the opcode, the byte enables and the offset. In indexed mode, requests that repeat the register of the open burst are merged into a single burst command. The header of that burst carries a running count, and the block writes the count again in place each time a data word is appended.

The packer keeps a free position counted in 32-bit words and remembers where the open burst header starts. Each new command starts on an even word. A burst that ends on an odd word is followed by a zero pad word, and the free position does not count that pad. A finish request fills the buffer with zero words up to the next 64-byte line and leaves the tail, in bytes, on a status output. A request that would not fit is taken from the port but not stored, and it raises a sticky overflow flag. Running the buffer is left to another block.

Top module: `cmd_packer`

## Requirements
- R1: After reset the block is ready, overflow is low, the tail is 0 and the memory write strobe is low. No indexed request can merge until a burst header has been written.
- R2: A direct request with room writes its data word at the free position rounded up to even (A). At A+1 it writes a header with 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0. The free position becomes A+2.
- R3: An indexed request that opens a burst first writes a count word of 0 at A. At A+1 it writes a header with 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0. It then appends its data word.
- R4: An indexed request whose offset equals that of the open burst writes no new header. The count word at the burst start is rewritten with the new number of data words, and the data word is written at the free position, which then grows by one.
- R5: After a data word is appended, a free position that is odd gets a zero word written at that position. The tail output always equals the free position times 4 and does not include the pad.
- R6: A direct request, an indexed request for a different offset, or a finish closes the open burst. The next indexed request then opens a new header.
- R7: A request that arrives while the free position is above capacity minus 2 words is accepted but writes nothing, and overflow is set. Overflow stays set until reset.
- R8: If a new burst header lands on the last two words of the buffer, the header stays with count 0, the data word is dropped and overflow is set.
- R9: A finish writes zero words from the free position up to the next 16-word (64-byte) line and moves the free position there. In the cycle after the last fill word it pulses done, with no write. A finish that is already aligned writes nothing.
- R10: Ready is low while a command is being written. A direct request occupies 2 cycles, a new burst 5, an append 2 or 3 with the pad, a refused request 0, and a finish one cycle per zero word plus one. A request takes priority over a finish presented in the same cycle.
- R11: The tail never decreases outside reset, and at most one memory word is written per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request or a finish |
| req_indexed | input | 1 | 1 = indexed (burst) mode, 0 = direct mode |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Register data |
| fin_valid | input | 1 | Finish request, taken when ready and no write request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | $clog2(CAP_WORDS) | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| tail_bytes | output | $clog2(CAP_WORDS)+3 | Free position in bytes |
| fin_done | output | 1 | One-cycle pulse when a finish completes |
| overflow | output | 1 | Sticky refused-request flag |

## Verification
The assertions run on every cycle. They check the state right after reset, the exact two words that a direct request writes, the refusal of a request when the buffer has no room, the stickiness of overflow, the rule that ready is low whenever a write happens, a tail that never moves back, and the line alignment at a finish pulse. Other behaviours need whole command sequences and only the bench scenarios can show them: merging versus opening a burst, the in-place rewrite of the count, the odd-word pads, burst closing by a direct write or a finish, and the header-at-the-end overflow. The bench checks these by comparing the full memory image against an arithmetic model, both in directed cases and in a sweep over every mode and offset pattern of five requests.

// File: rtl/cmd_packer_pkg.sv
package cmd_packer_pkg;

    localparam int OFS_W  = 20;
    localparam int WORD_W = 32;

    localparam logic [7:0] OPC_DIRECT  = 8'h01;
    localparam logic [7:0] OPC_BURST   = 8'h09;
    localparam logic [3:0] BYTE_EN_ALL = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIR_LO,
        ST_DIR_HI,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_CNT,
        ST_DATA,
        ST_PAD,
        ST_FILL
    } pk_state_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [WORD_W-1:0] data;
    } pk_req_t;

    function automatic logic [WORD_W-1:0] direct_hdr(input logic [OFS_W-1:0] ofs);
        return {OPC_DIRECT, BYTE_EN_ALL, ofs};
    endfunction

    function automatic logic [WORD_W-1:0] burst_hdr(input logic [OFS_W-1:0] ofs);
        return {OPC_BURST, 4'h0, ofs};
    endfunction

endpackage

// File: rtl/pk_room.sv
module pk_room #(
    parameter int CAP_WORDS  = 64,
    parameter int LINE_WORDS = 16,
    localparam int FP_W      = $clog2(CAP_WORDS) + 1,
    localparam int LB        = $clog2(LINE_WORDS)
) (
    input  logic [FP_W-1:0] fp,
    output logic [FP_W-1:0] even_pos,
    output logic            has_room,
    output logic            line_aligned
);
    localparam logic [FP_W-1:0] ROOM_MAX = FP_W'(CAP_WORDS - 2);

    always_comb begin
        even_pos     = fp + FP_W'(fp[0]);
        has_room     = (fp <= ROOM_MAX);
        line_aligned = (fp[LB-1:0] == '0);
    end
endmodule

// File: rtl/pk_hdr_track.sv
module pk_hdr_track
    import cmd_packer_pkg::*;
#(
    parameter int AW   = 6,
    localparam int FP_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_burst,
    input  logic [AW-1:0]     open_start,
    input  logic [OFS_W-1:0]  open_ofs,
    input  logic              bump,
    input  logic              close_burst,
    input  logic [OFS_W-1:0]  probe_ofs,
    output logic              hit,
    output logic [AW-1:0]     start,
    output logic [WORD_W-1:0] cnt_next
);
    logic              hv;
    logic [OFS_W-1:0]  hreg;
    logic [FP_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hv    <= 1'b0;
            hreg  <= '0;
            cnt   <= '0;
            start <= '0;
        end else if (close_burst) begin
            hv <= 1'b0;
        end else if (open_burst) begin
            hv    <= 1'b1;
            hreg  <= open_ofs;
            start <= open_start;
            cnt   <= '0;
        end else if (bump) begin
            cnt <= cnt + FP_W'(1);
        end
    end

    always_comb begin
        hit      = hv && (hreg == probe_ofs);
        cnt_next = WORD_W'(cnt) + WORD_W'(1);
    end
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
    import cmd_packer_pkg::*;
#(
    parameter int CAP_WORDS  = 64,
    parameter int LINE_BYTES = 64,
    localparam int AW         = $clog2(CAP_WORDS),
    localparam int FP_W       = AW + 1,
    localparam int TB_W       = FP_W + 2,
    localparam int LINE_WORDS = LINE_BYTES / 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_indexed,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [WORD_W-1:0] req_data,
    input  logic              fin_valid,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [TB_W-1:0]   tail_bytes,
    output logic              fin_done,
    output logic              overflow
);
    localparam logic [FP_W-1:0] ROOM_MAX = FP_W'(CAP_WORDS - 2);

    pk_state_e       state;
    logic [FP_W-1:0] fp;
    logic [AW-1:0]   base;
    pk_req_t         lat;
    logic            ovf;

    logic [FP_W-1:0] even_pos;
    logic            has_room, line_aligned;
    logic            trk_hit, trk_open, trk_bump, trk_close;
    logic [AW-1:0]   trk_start;
    logic [WORD_W-1:0] trk_cnt_next;
    logic [FP_W-1:0] after_hdr;
    logic            hdr_room;
    logic            take_req, take_fin;

    pk_room #(.CAP_WORDS(CAP_WORDS), .LINE_WORDS(LINE_WORDS)) u_room (
        .fp           (fp),
        .even_pos     (even_pos),
        .has_room     (has_room),
        .line_aligned (line_aligned)
    );

    pk_hdr_track #(.AW(AW)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .open_burst  (trk_open),
        .open_start  (base),
        .open_ofs    (lat.ofs),
        .bump        (trk_bump),
        .close_burst (trk_close),
        .probe_ofs   (req_offset),
        .hit         (trk_hit),
        .start       (trk_start),
        .cnt_next    (trk_cnt_next)
    );

    always_comb begin
        take_req  = (state == ST_IDLE) && req_valid;
        take_fin  = (state == ST_IDLE) && !req_valid && fin_valid;
        after_hdr = {1'b0, base} + FP_W'(2);
        hdr_room  = (after_hdr <= ROOM_MAX);
        trk_open  = (state == ST_HDR_HI);
        trk_bump  = (state == ST_CNT);
        trk_close = (take_req && !req_indexed && has_room) || take_fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fp    <= '0;
            base  <= '0;
            lat   <= '0;
            ovf   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat <= '{ofs: req_offset, data: req_data};
                        if (req_indexed && trk_hit) begin
                            if (has_room) state <= ST_CNT;
                            else          ovf   <= 1'b1;
                        end else if (!has_room) begin
                            ovf <= 1'b1;
                        end else begin
                            base  <= even_pos[AW-1:0];
                            state <= req_indexed ? ST_HDR_LO : ST_DIR_LO;
                        end
                    end else if (fin_valid) begin
                        state <= ST_FILL;
                    end
                end
                ST_DIR_LO: state <= ST_DIR_HI;
                ST_DIR_HI: begin
                    fp    <= after_hdr;
                    state <= ST_IDLE;
                end
                ST_HDR_LO: state <= ST_HDR_HI;
                ST_HDR_HI: begin
                    fp <= after_hdr;
                    if (hdr_room) begin
                        state <= ST_CNT;
                    end else begin
                        ovf   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_CNT: state <= ST_DATA;
                ST_DATA: begin
                    fp    <= fp + FP_W'(1);
                    state <= fp[0] ? ST_IDLE : ST_PAD;
                end
                ST_PAD: state <= ST_IDLE;
                ST_FILL: begin
                    if (line_aligned) state <= ST_IDLE;
                    else              fp    <= fp + FP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_DIR_LO: begin
                mem_we = 1'b1; mem_addr = base; mem_wdata = lat.data;
            end
            ST_DIR_HI: begin
                mem_we = 1'b1; mem_addr = base + AW'(1); mem_wdata = direct_hdr(lat.ofs);
            end
            ST_HDR_LO: begin
                mem_we = 1'b1; mem_addr = base;
            end
            ST_HDR_HI: begin
                mem_we = 1'b1; mem_addr = base + AW'(1); mem_wdata = burst_hdr(lat.ofs);
            end
            ST_CNT: begin
                mem_we = 1'b1; mem_addr = trk_start; mem_wdata = trk_cnt_next;
            end
            ST_DATA: begin
                mem_we = 1'b1; mem_addr = fp[AW-1:0]; mem_wdata = lat.data;
            end
            ST_PAD: begin
                mem_we = 1'b1; mem_addr = fp[AW-1:0];
            end
            ST_FILL: begin
                mem_we = !line_aligned; mem_addr = fp[AW-1:0];
            end
            default: ;
        endcase
    end

    assign req_ready  = (state == ST_IDLE);
    assign tail_bytes = {fp, 2'b00};
    assign fin_done   = (state == ST_FILL) && line_aligned;
    assign overflow   = ovf;

endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
    parameter int CAP_WORDS = 64,
    localparam int AW   = $clog2(CAP_WORDS),
    localparam int TB_W = AW + 3
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_indexed,
    input logic [19:0]     req_offset,
    input logic [31:0]     req_data,
    input logic            mem_we,
    input logic [31:0]     mem_wdata,
    input logic [TB_W-1:0] tail_bytes,
    input logic            fin_done,
    input logic            overflow
);
    localparam logic [TB_W-1:0] ROOM_LIM = TB_W'(4 * (CAP_WORDS - 2));

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !overflow && tail_bytes == '0 && !mem_we));

    p_direct_words_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_indexed && tail_bytes <= ROOM_LIM)
        |=> (mem_we && mem_wdata == $past(req_data))
            ##1 (mem_we && mem_wdata == {8'h01, 4'hF, $past(req_offset, 2)}));

    p_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && tail_bytes > ROOM_LIM)
        |=> (req_ready && !mem_we && overflow));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_done_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        fin_done |-> (tail_bytes[5:0] == 6'd0 && !mem_we && !req_ready));

    p_busy_on_write_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !req_ready);

    p_tail_monotonic_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tail_bytes >= $past(tail_bytes)));

endmodule

bind cmd_packer cmd_packer_chk #(.CAP_WORDS(CAP_WORDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .req_data    (req_data),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .tail_bytes  (tail_bytes),
    .fin_done    (fin_done),
    .overflow    (overflow)
);

// File: tb/sim_cmd_packer.sv
module sim_cmd_packer;
    localparam int CAP  = 64;
    localparam int AW   = 6;
    localparam int TB_W = 9;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam logic [19:0] OFS_A = 20'h0_1234;
    localparam logic [19:0] OFS_B = 20'hF_0008;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic            req_valid = 1'b0, req_indexed = 1'b0, fin_valid = 1'b0;
    logic [19:0]     req_offset = '0;
    logic [31:0]     req_data = '0;
    logic            req_ready, mem_we, fin_done, overflow;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [TB_W-1:0] tail_bytes;

    cmd_packer #(.CAP_WORDS(CAP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_indexed(req_indexed), .req_offset(req_offset), .req_data(req_data),
        .fin_valid(fin_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .tail_bytes(tail_bytes), .fin_done(fin_done),
        .overflow(overflow)
    );

    logic [31:0] bmem [CAP];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CAP; i++) bmem[i] <= SENT;
        end else if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
        end
    end

    logic [31:0] emem [CAP];
    int          m_fp, m_hs, m_cnt, m_busy;
    logic [19:0] m_hreg;
    bit          m_hv, m_ovf;
    int          checks = 0;
    int          errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < CAP; i++) emem[i] = SENT;
        m_fp = 0; m_hs = 0; m_cnt = 0; m_hreg = '0; m_hv = 0; m_ovf = 0; m_busy = 0;
    endtask

    task automatic model_append(input logic [31:0] d);
        m_cnt++;
        emem[m_hs] = m_cnt;
        emem[m_fp] = d;
        m_fp++;
        m_busy += 2;
        if (m_fp % 2 == 1) begin
            emem[m_fp] = 32'h0;
            m_busy++;
        end
    endtask

    task automatic model_req(input bit idx, input logic [19:0] off, input logic [31:0] d);
        int a;
        m_busy = 0;
        if (idx && m_hv && m_hreg == off) begin
            if (m_fp > CAP - 2) m_ovf = 1;
            else model_append(d);
        end else if (m_fp > CAP - 2) begin
            m_ovf = 1;
        end else begin
            a = m_fp + (m_fp % 2);
            if (!idx) begin
                emem[a]     = d;
                emem[a + 1] = {8'h01, 4'hF, off};
                m_fp = a + 2; m_hv = 0; m_busy = 2;
            end else begin
                emem[a]     = 32'h0;
                emem[a + 1] = {8'h09, 4'h0, off};
                m_fp = a + 2; m_hv = 1; m_hs = a; m_cnt = 0; m_hreg = off; m_busy = 2;
                if (m_fp > CAP - 2) m_ovf = 1;
                else model_append(d);
            end
        end
    endtask

    task automatic model_fin();
        m_hv = 0;
        m_busy = 1;
        while (m_fp % 16 != 0) begin
            emem[m_fp] = 32'h0;
            m_fp++;
            m_busy++;
        end
    endtask

    // One request or finish; checks busy length (R10), overflow (R7), tail (R5), done pulse (R9)
    task automatic issue(input bit isfin, input bit idx, input logic [19:0] off,
                         input logic [31:0] d);
        int busy, dones;
        if (isfin) model_fin(); else model_req(idx, off, d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (isfin) fin_valid = 1'b1;
        else begin
            req_valid = 1'b1; req_indexed = idx; req_offset = off; req_data = d;
        end
        @(negedge clk);
        req_valid = 1'b0; fin_valid = 1'b0;
        busy = 0; dones = 0;
        while (!req_ready && busy < 100) begin
            if (fin_done) dones++;
            busy++;
            @(negedge clk);
        end
        chk("R10 busy cycles", busy, m_busy);
        chk("R7 overflow flag", {31'b0, overflow}, {31'b0, m_ovf});
        chk("R5 tail bytes", {23'b0, tail_bytes}, m_fp * 4);
        if (isfin) chk("R9 done pulses", dones, 1);
    endtask

    task automatic cmp_image(input string tag);
        for (int i = 0; i < CAP; i++) chk(tag, bmem[i], emem[i]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 ready", {31'b0, req_ready}, 32'h1);
        chk("R1 overflow", {31'b0, overflow}, 32'h0);
        chk("R1 tail", {23'b0, tail_bytes}, 32'h0);
        chk("R1 no write", {31'b0, mem_we}, 32'h0);

        // R2: direct write
        issue(0, 0, 20'h00100, 32'hAAAA_0001);
        chk("R2 data word", bmem[0], 32'hAAAA_0001);
        chk("R2 header word", bmem[1], 32'h01F0_0100);

        // R3/R4/R5: burst open and merges
        issue(0, 1, 20'h00200, 32'h1111_0001);
        chk("R3 burst header", bmem[3], 32'h0900_0200);
        chk("R5 pad after first", bmem[5], 32'h0);
        issue(0, 1, 20'h00200, 32'h1111_0002);
        issue(0, 1, 20'h00200, 32'h1111_0003);
        chk("R4 count word", bmem[2], 32'd3);
        chk("R4 appended data", bmem[6], 32'h1111_0003);
        chk("R5 odd pad", bmem[7], 32'h0);
        chk("R5 tail excludes pad", {23'b0, tail_bytes}, 32'd28);

        // R6: different offset, then direct closes, then same offset reopens
        issue(0, 1, 20'h00300, 32'h2222_0001);
        issue(0, 0, 20'h00300, 32'h3333_0001);
        issue(0, 1, 20'h00300, 32'h2222_0002);
        chk("R6 new header after direct", bmem[15], 32'h0900_0300);
        chk("R6 new count", bmem[14], 32'd1);
        cmp_image("R6 image");

        // R9: finish and aligned finish
        issue(1, 0, '0, '0);
        chk("R9 tail at line", {23'b0, tail_bytes}, 32'd128);
        issue(1, 0, '0, '0);
        cmp_image("R9 image");

        // R6: finish closes burst
        issue(0, 1, 20'h00300, 32'h2222_0003);
        chk("R6 header after finish", bmem[33], 32'h0900_0300);

        // R10: request and finish together, request first
        model_req(0, 20'h00400, 32'h4444_0001);
        model_fin();
        @(negedge clk);
        req_valid = 1'b1; req_indexed = 1'b0; req_offset = 20'h00400;
        req_data = 32'h4444_0001; fin_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        fin_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        chk("R10 request before finish tail", {23'b0, tail_bytes}, m_fp * 4);
        cmp_image("R10 image");

        // R7: append until refused
        for (int k = 0; k < 20; k++) issue(0, 1, 20'h00500, 32'h5555_0000 + k);
        chk("R7 overflow set", {31'b0, overflow}, 32'h1);
        issue(0, 0, 20'h00600, 32'h6666_0001);
        chk("R7 overflow sticky", {31'b0, overflow}, 32'h1);
        cmp_image("R7 image");

        // R8: header on the last two words
        do_reset();
        for (int k = 0; k < 31; k++) issue(0, 0, 20'h00010, k);
        issue(0, 1, 20'h00020, 32'h7777_0001);
        chk("R8 count stays 0", bmem[62], 32'h0);
        chk("R8 header kept", bmem[63], 32'h0900_0020);
        chk("R8 overflow", {31'b0, overflow}, 32'h1);
        issue(1, 0, '0, '0);
        cmp_image("R8 image");

        // Sweep: every mode/offset pattern of five requests, then finish (R2 R3 R4 R5 R6)
        for (int pat = 0; pat < 1024; pat++) begin
            do_reset();
            for (int k = 0; k < 5; k++) begin
                issue(0, pat[2*k], pat[2*k+1] ? OFS_A : OFS_B, {pat[15:0], 16'(k)});
            end
            issue(1, 0, '0, '0);
            cmp_image("R4 sweep image");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule